// File: doc/BRIEF.md
# Two-Source Video Interrupt Controller

This block turns two video timing events into a single prioritised interrupt request for a processor. A once-per-scanline event and a once-per-frame event each set their own sticky request flag. Each source has an enable input taken from the display control registers. The block drives a 3-bit interrupt level and reports which source that level belongs to. On an acknowledge it retires only the request being serviced.

The frame source outranks the line source. The level is computed from the stored flags and the live enables. Turning an enable on or off while a request waits therefore changes the level in the same cycle. A request that arrives while its enable is low is kept, and it is presented as soon as the enable rises. The frame flag is also brought out on its own, so it can be placed in bit 7 of a status word.

Top module: `vid_irq_ctrl`

## Requirements
- R1: An event pulse sampled at a rising clock edge sets that source's request flag from the next cycle onward. The flag then holds until an acknowledge retires it, whatever the enables do.
- R2: While the frame flag is set and `frame_en` is 1, `irq_level` is FRAME_LVL (default 6), whatever the line source is doing.
- R3: Otherwise `irq_level` is LINE_LVL (default 4) when the line flag is set and `line_en` is 1, and 0 in every other case, including during and directly after reset. No other level value ever appears.
- R4: A change of either enable changes `irq_level` in the same cycle, with no clock edge needed. Disabling a source does not drop its stored request.
- R5: An acknowledge sampled while `svc_frame` is 1 clears the frame flag, and with it `frame_flag`, from the next cycle. It leaves the line flag untouched.
- R6: An acknowledge sampled while `svc_frame` is 0 clears the line flag and leaves the frame flag untouched. This holds even when `irq_level` is 0 or the line source is disabled.
- R7: An event on one source in the same cycle as an acknowledge that retires the other source is kept.
- R8: An event on the same source that an acknowledge retires in that cycle wins, and the flag stays set (default SET_WINS=1). With SET_WINS=0 the clear wins.
- R9: `frame_flag` equals the frame request flag: it is 1 from the cycle after a frame event until the cycle after the acknowledge that retires it.
- R10: `svc_frame` is 1 exactly when the frame flag is set and `frame_en` is 1, that is, when the frame source owns the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_evt | input | 1 | One-cycle pulse per scanline |
| frame_evt | input | 1 | One-cycle pulse per frame |
| line_en | input | 1 | Line interrupt enable (control register 0 bit 4) |
| frame_en | input | 1 | Frame interrupt enable (control register 1 bit 5) |
| irq_ack | input | 1 | Processor interrupt acknowledge strobe |
| irq_level | output | LVL_W (3) | Requested interrupt level: 0, LINE_LVL or FRAME_LVL |
| svc_frame | output | 1 | 1 when the frame source owns the level, 0 otherwise |
| frame_flag | output | 1 | Frame request flag, for status bit 7 |

## Verification
On every cycle, the embedded properties check four things: flags set after events, flags hold between events and acknowledges, an acknowledge retires only the serviced source, and the level is always one of the three legal values with the frame source first. The same-cycle response of the level to an enable toggle is combinational, so only the bench's comparisons show it. The same is true of a line request surviving a long disabled stretch, and of the exact ordering across scripted collisions of events with acknowledges.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
   typedef enum logic {
      SRC_LINE  = 1'b0,
      SRC_FRAME = 1'b1
   } irq_src_e;
endpackage

// File: rtl/vid_irq_pend.sv
module vid_irq_pend #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;
   logic q_nxt;

   generate
      if (SET_WINS) begin : g_set_wins
         assign q_nxt = set_i | (q_r & ~clr_i);
      end else begin : g_clr_wins
         assign q_nxt = ~clr_i & (set_i | q_r);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= q_nxt;
   end

   assign q_o = q_r;

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && (SET_WINS || !clr_i)) |=> q_o);                 // R1
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);                              // R5
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));                     // R1
endmodule

// File: rtl/vid_irq_prio.sv
module vid_irq_prio
   import vid_irq_pkg::*;
#(
   parameter int LVL_W     = 3,
   parameter int FRAME_LVL = 6,
   parameter int LINE_LVL  = 4
) (
   input  logic             line_pend,
   input  logic             line_en,
   input  logic             frame_pend,
   input  logic             frame_en,
   output logic [LVL_W-1:0] level_o,
   output irq_src_e         src_o
);
   localparam logic [LVL_W-1:0] FRAME_CODE = LVL_W'(FRAME_LVL);
   localparam logic [LVL_W-1:0] LINE_CODE  = LVL_W'(LINE_LVL);

   logic frame_act;
   logic line_act;

   assign frame_act = frame_pend & frame_en;
   assign line_act  = line_pend & line_en;

   always_comb begin
      if (frame_act) begin
         level_o = FRAME_CODE;
         src_o   = SRC_FRAME;
      end else if (line_act) begin
         level_o = LINE_CODE;
         src_o   = SRC_LINE;
      end else begin
         level_o = '0;
         src_o   = SRC_LINE;
      end
   end
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
   import vid_irq_pkg::*;
#(
   parameter int LVL_W     = 3,
   parameter int FRAME_LVL = 6,
   parameter int LINE_LVL  = 4,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_evt,
   input  logic             frame_evt,
   input  logic             line_en,
   input  logic             frame_en,
   input  logic             irq_ack,
   output logic [LVL_W-1:0] irq_level,
   output logic             svc_frame,
   output logic             frame_flag
);
   localparam int MAX_LVL = (1 << LVL_W) - 1;

   generate
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_width
         $error("vid_irq_ctrl: LVL_W out of range");
      end
      if (FRAME_LVL > MAX_LVL || LINE_LVL < 1) begin : g_bad_level
         $error("vid_irq_ctrl: level does not fit LVL_W or is zero");
      end
      if (FRAME_LVL <= LINE_LVL) begin : g_bad_order
         $error("vid_irq_ctrl: frame level must exceed line level");
      end
   endgenerate

   logic     line_pend;
   logic     frame_pend;
   logic     line_clr;
   logic     frame_clr;
   irq_src_e src;

   // Source selection is taken from the same registered flags that drive the level.
   assign frame_clr = irq_ack & (src == SRC_FRAME);
   assign line_clr  = irq_ack & (src == SRC_LINE);

   vid_irq_pend #(.SET_WINS(SET_WINS)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (line_evt),
      .clr_i (line_clr),
      .q_o   (line_pend)
   );

   vid_irq_pend #(.SET_WINS(SET_WINS)) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (frame_evt),
      .clr_i (frame_clr),
      .q_o   (frame_pend)
   );

   vid_irq_prio #(
      .LVL_W     (LVL_W),
      .FRAME_LVL (FRAME_LVL),
      .LINE_LVL  (LINE_LVL)
   ) u_prio (
      .line_pend  (line_pend),
      .line_en    (line_en),
      .frame_pend (frame_pend),
      .frame_en   (frame_en),
      .level_o    (irq_level),
      .src_o      (src)
   );

   assign svc_frame  = (src == SRC_FRAME);
   assign frame_flag = frame_pend;

   AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_flag && frame_en) |-> (irq_level == LVL_W'(FRAME_LVL)));          // R2
   AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == '0) || (irq_level == LVL_W'(LINE_LVL))
      || (irq_level == LVL_W'(FRAME_LVL)));                                    // R3
   AST_ACK_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && svc_frame && !frame_evt) |=> !frame_flag);                   // R5
   AST_ACK_LINE_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !svc_frame && frame_flag) |=> frame_flag);                   // R6
   AST_ACK_FRAME_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && svc_frame && line_pend) |=> line_pend);                      // R7
   AST_SAME_SRC_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && svc_frame && frame_evt) |=> (frame_flag == SET_WINS));       // R8
endmodule

// File: tb/sim_vid_irq_ctrl.sv
module sim_vid_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_evt = 1'b0, frame_evt = 1'b0;
   logic       line_en = 1'b0, frame_en = 1'b0, irq_ack = 1'b0;
   logic [2:0] irq_level;
   logic       svc_frame, frame_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int m_line = 0;
   int m_frame = 0;

   always #2 clk = ~clk;

   vid_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .line_evt(line_evt), .frame_evt(frame_evt),
      .line_en(line_en), .frame_en(frame_en), .irq_ack(irq_ack),
      .irq_level(irq_level), .svc_frame(svc_frame), .frame_flag(frame_flag)
   );

   // Behavioural reference: two sticky flags, frame first, new event beats clear.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_line = 0;
         m_frame = 0;
      end else begin
         bit serv_frame;
         serv_frame = (m_frame != 0) && frame_en;
         if (irq_ack) begin
            if (serv_frame) m_frame = 0;
            else            m_line = 0;
         end
         if (frame_evt) m_frame = 1;
         if (line_evt)  m_line = 1;
      end
   end

   function automatic int exp_level();
      if (m_frame != 0 && frame_en) return 6;
      if (m_line != 0 && line_en)   return 4;
      return 0;
   endfunction

   task automatic compare(string tag);
      int el;
      el = exp_level();
      n_chk++;
      if (int'(irq_level) != el) begin
         n_bad++;
         $display("FAIL %s irq_level actual=%0d expected=%0d", tag, irq_level, el);
      end
      n_chk++;
      if (svc_frame != (m_frame != 0 && frame_en)) begin
         n_bad++;
         $display("FAIL %s R10 svc_frame actual=%0d expected=%0d", tag, svc_frame,
                  (m_frame != 0 && frame_en));
      end
      n_chk++;
      if (frame_flag != (m_frame != 0)) begin
         n_bad++;
         $display("FAIL %s R9 frame_flag actual=%0d expected=%0d", tag, frame_flag,
                  (m_frame != 0));
      end
   endtask

   task automatic step(bit le, bit fe, bit len, bit fen, bit ack, string tag);
      @(negedge clk);
      line_evt = le; frame_evt = fe; line_en = len; frame_en = fen; irq_ack = ack;
      #1 compare(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R3 reset");
      rst_n = 1'b1;
      step(0, 1, 0, 0, 0, "R1");   // frame event while disabled
      step(0, 0, 0, 0, 0, "R1");   // flag held, level 0
      step(0, 0, 0, 1, 0, "R4");   // enable rises: level 6 at once
      step(1, 0, 0, 1, 0, "R1");
      step(0, 0, 1, 1, 0, "R2");   // both pending and enabled
      step(0, 0, 1, 1, 1, "R5");   // ack the frame request
      step(0, 0, 1, 1, 0, "R5");   // line level 4 remains
      step(0, 0, 0, 1, 0, "R4");   // line disabled: level 0, kept
      step(0, 0, 0, 0, 0, "R4");
      step(0, 0, 1, 0, 0, "R4");   // re-enabled: level 4
      step(0, 1, 1, 1, 1, "R7");   // ack line while a frame event lands
      step(0, 0, 1, 1, 0, "R7");
      step(0, 1, 1, 1, 1, "R8");   // ack frame with a frame event
      step(0, 0, 1, 1, 0, "R8");
      step(1, 0, 1, 1, 1, "R7");   // ack frame with a line event
      step(0, 0, 1, 1, 0, "R7");
      step(0, 0, 1, 1, 1, "R6");   // ack the line request
      step(0, 0, 1, 1, 0, "R6");
      step(1, 0, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 1, "R6");   // ack at level 0 retires line flag
      step(0, 0, 1, 0, 0, "R6");   // line enable shows nothing left
      step(0, 0, 1, 0, 0, "R3");
      for (int i = 0; i < 4000; i++) begin
         bit le, fe, len, fen, ack;
         le  = ($urandom_range(0, 7) == 0);
         fe  = ($urandom_range(0, 15) == 0);
         len = ($urandom_range(0, 3) != 0);
         fen = ($urandom_range(0, 3) != 0);
         ack = ($urandom_range(0, 4) == 0);
         step(le, fe, len, fen, ack, "R1 R2 R3 R5 R6 R7 R8 random");
      end
      step(0, 0, 0, 0, 0, "R3");
      finish_run();
   end
endmodule